// File: doc/BRIEF.md
# Parallel-MRI Unfolding Load and Sequencing Controller

This block sits in front of a parallel-MRI unfolding engine and owns the three memories the engine works from and into. Coefficients of the encoding matrix arrive one word per cycle while a coefficient strobe is held high. Undersampled coil samples arrive the same way under a separate sample strobe. Each word is 64 bits: the real part in bits [63:32] and the imaginary part in bits [31:0]. The controller stores these words without looking inside them. The engine reads both memories through their read ports.

Once both memories hold a complete set, the controller raises a ready level and walks the pixel groups in order. For each group it gives the engine a one-cycle go pulse and the group index. It then waits for the engine's done flag and stores the engine's ACCEL result words into the image memory at ACCEL consecutive addresses. When the last group completes, it issues a one-cycle completion pulse and requires fresh loads before the next frame. A load strobe seen while reconstruction is in progress is discarded, and a sticky error bit records it.

Top module: `recon_seq_ctrl`

## Requirements
- R1: While `coef_load` is high, each cycle's `coef_word` is written to the coefficient memory at consecutive addresses starting at 0. Words beyond COEF_DEPTH in one strobe period are dropped, so the last address keeps word COEF_DEPTH-1.
- R2: While `data_load` is high, each cycle's `samp_word` is written to the sample memory in the same way, up to SAMP_DEPTH words. A sample load may overlap a coefficient load cycle for cycle.
- R3: Each new rising edge of a strobe restarts its memory's address at 0. A strobe period shorter than the depth does not count as a complete load.
- R4: `eng_ready` stays low until both memories are complete. It goes high in the cycle after the last strobe to fall is seen low.
- R5: `eng_go` is a one-cycle pulse issued once per group, with `eng_group` counting 0 to NUM_GROUPS-1 in ascending order. Each later pulse comes in the cycle after the previous group's done is accepted.
- R6: `eng_done` is accepted only in the wait state, the cycle after a go pulse or later. A done raised in the go cycle has no effect.
- R7: An accepted done for group g writes lane k of `eng_result` (bits k*64 +: 64) to image address g*ACCEL+k, readable on `img_raddr`/`img_rdata`.
- R8: After the last group's done, `all_done` is high for exactly one cycle, the state becomes finished and `eng_ready` drops. Both completeness flags are cleared, so a new frame needs both memories reloaded before `eng_ready` rises again.
- R9: A strobe that is high while `eng_ready` is high writes nothing and sets `seq_err`. `seq_err` stays set until reset.
- R10: `seq_state` reports 0 idle, 1 coefficient load, 2 sample load, 3 run (go cycle), 4 waiting for done, 5 finished. When both strobes rise together, the state shows coefficient load.
- R11: After a synchronous active-low reset: state 0, `eng_ready`, `eng_go`, `all_done` and `seq_err` all low, and neither memory counts as complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| coef_load | input | 1 | Coefficient load strobe |
| coef_word | input | 64 | Coefficient word (real high, imaginary low) |
| data_load | input | 1 | Coil sample load strobe |
| samp_word | input | 64 | Coil sample word (real high, imaginary low) |
| coef_raddr | input | 3 | Coefficient memory read address |
| coef_rdata | output | 64 | Coefficient memory read data |
| samp_raddr | input | 3 | Sample memory read address |
| samp_rdata | output | 64 | Sample memory read data |
| eng_ready | output | 1 | Both memories loaded, reconstruction active |
| eng_go | output | 1 | Start pulse for one pixel group |
| eng_group | output | 2 | Index of the current pixel group |
| eng_done | input | 1 | Engine finished the current group |
| eng_result | input | 128 | ACCEL result words for the current group |
| img_raddr | input | 3 | Image memory read address |
| img_rdata | output | 64 | Image memory read data |
| seq_state | output | 3 | Sequencer state code |
| all_done | output | 1 | One-cycle pulse after the last group |
| seq_err | output | 1 | Sticky strobe-during-reconstruction error |

## Verification
Two events can fall in the same cycle: the engine's done for the final group, and a load strobe arriving while the controller still waits for that done. The bench raises `coef_load` in exactly the cycle it returns the last done. It then expects three things together: the result lands in the image memory, `all_done` pulses with the state reaching finished, and `seq_err` is set. It also reads the coefficient memory back to confirm that the stray word did not overwrite address 0. A second collision, a done raised in the go cycle, is provoked in the same run. It is judged by the state moving to the wait state rather than to the next group.

// File: rtl/recon_seq_pkg.sv
// Shared definitions for the unfolding load and sequencing controller.
// Assumes: state codes are visible at the top ports, so their values are fixed.
package recon_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_LOAD_COEF = 3'd1,
        ST_LOAD_DATA = 3'd2,
        ST_RUN       = 3'd3,
        ST_WAIT_DONE = 3'd4,
        ST_FINISHED  = 3'd5
    } seq_state_e;

endpackage

// File: rtl/recon_load_bank.sv
// Strobe-driven load memory: while the strobe is high and loading is open,
// one word per cycle is written at an address that restarts at 0 on each
// rising edge of the strobe. Words past DEPTH are dropped. A completeness
// flag is set by the write to the last address and cleared on a new rising
// edge or on the frame clear. Read port is asynchronous for the engine.
// Assumes: clear and an accepted write never coincide (the sequencer closes
// loading while it can raise clear).
module recon_load_bank #(
    parameter  int DEPTH  = 8,
    parameter  int WORD_W = 64,
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              open,
    input  logic              clear,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata,
    output logic              full
);

    logic              strobe_q;
    logic              rise;
    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     base;
    logic              we;
    logic [AW-1:0]     waddr;
    logic              full_q;
    logic [WORD_W-1:0] mem [DEPTH];

    // Address for this cycle: 0 on a rising strobe, else the running count.
    always_comb begin
        rise  = strobe & ~strobe_q;
        base  = rise ? '0 : cnt_q;
        we    = strobe & open & (base < CW'(DEPTH));
        waddr = base[AW-1:0];
    end

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // Advance the write count per accepted word; saturate at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= CW'(DEPTH);
        else if (strobe && open)   cnt_q <= we ? base + 1'b1 : base;
    end

    // Completeness flag: set by the last-address write, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 full_q <= 1'b0;
        else if (clear)                             full_q <= 1'b0;
        else if (we && base == CW'(DEPTH - 1))      full_q <= 1'b1;
        else if (rise && open)                      full_q <= 1'b0;
    end

    // Store the accepted word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
    assign full  = full_q;

    AST_FULL_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == AW'(DEPTH - 1)) |=> full);                       // R1
    AST_FULL_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !strobe && !clear) |=> full);                           // R3

endmodule

// File: rtl/recon_seq_fsm.sv
// Sequencer: tracks the load phases, opens reconstruction once both
// memories are complete, issues one go pulse per pixel group, accepts the
// engine's done only while waiting, and flags strobes seen mid-run.
// Assumes: the engine holds eng_done for one cycle per group.
module recon_seq_fsm
    import recon_seq_pkg::*;
#(
    parameter  int NUM_GROUPS = 4,
    localparam int GW         = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           coef_load,
    input  logic           data_load,
    input  logic           coef_full,
    input  logic           samp_full,
    input  logic           eng_done,
    output seq_state_e     state_o,
    output logic           load_open,
    output logic           eng_ready,
    output logic           eng_go,
    output logic [GW-1:0]  group,
    output logic           img_we,
    output logic           frame_clear,
    output logic           all_done,
    output logic           err
);

    seq_state_e    state_q, state_d;
    logic [GW-1:0] group_q;
    logic          last;
    logic          both_full;
    logic          entering_run;
    logic          all_done_q;
    logic          err_q;

    // Decode helpers shared by the next-state logic and the outputs.
    always_comb begin
        both_full    = coef_full & samp_full;
        last         = (group_q == GW'(NUM_GROUPS - 1));
        load_open    = (state_q != ST_RUN) && (state_q != ST_WAIT_DONE);
        eng_ready    = !load_open;
        eng_go       = (state_q == ST_RUN);
        img_we       = (state_q == ST_WAIT_DONE) && eng_done;
        frame_clear  = img_we && last;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FINISHED: begin
                if (coef_load)      state_d = ST_LOAD_COEF;
                else if (data_load) state_d = ST_LOAD_DATA;
                else if (both_full) state_d = ST_RUN;
            end
            ST_LOAD_COEF: begin
                if (!coef_load) begin
                    if (data_load)      state_d = ST_LOAD_DATA;
                    else if (both_full) state_d = ST_RUN;
                    else                state_d = ST_IDLE;
                end
            end
            ST_LOAD_DATA: begin
                if (!data_load) begin
                    if (coef_load)      state_d = ST_LOAD_COEF;
                    else if (both_full) state_d = ST_RUN;
                    else                state_d = ST_IDLE;
                end
            end
            ST_RUN:       state_d = ST_WAIT_DONE;
            ST_WAIT_DONE: if (eng_done) state_d = last ? ST_FINISHED : ST_RUN;
            default:      state_d = ST_IDLE;
        endcase
        entering_run = (state_d == ST_RUN) && load_open;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Group index: restart at a new run, step after each accepted done.
    always_ff @(posedge clk) begin
        if (!rst_n)              group_q <= '0;
        else if (entering_run)   group_q <= '0;
        else if (img_we && !last) group_q <= group_q + 1'b1;
    end

    // Completion pulse and sticky strobe error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            all_done_q <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            all_done_q <= frame_clear;
            err_q      <= err_q | ((coef_load | data_load) & ~load_open);
        end
    end

    assign state_o  = state_q;
    assign group    = group_q;
    assign all_done = all_done_q;
    assign err      = err_q;

    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |=> !eng_go);                                              // R5
    AST_GROUP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(group) < NUM_GROUPS);                                         // R5
    AST_RUN_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (state_q == ST_WAIT_DONE));               // R6
    AST_ALL_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        all_done |=> !all_done);                                          // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);                                                     // R9

endmodule

// File: rtl/recon_img_store.sv
// Output image memory built from ACCEL lane banks. One accepted done writes
// every lane of the current group in a single cycle; image address
// g*ACCEL+k maps to bank k, row g. The read port is asynchronous.
// Assumes: group stays below NUM_GROUPS.
module recon_img_store #(
    parameter  int ACCEL      = 2,
    parameter  int NUM_GROUPS = 4,
    parameter  int WORD_W     = 64,
    localparam int DEPTH      = ACCEL * NUM_GROUPS,
    localparam int AW         = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int GW         = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int LW         = (ACCEL > 1) ? $clog2(ACCEL) : 1
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [GW-1:0]           group,
    input  logic [ACCEL*WORD_W-1:0] lanes,
    input  logic [AW-1:0]           raddr,
    output logic [WORD_W-1:0]       rdata
);

    logic [GW-1:0]     rd_group;
    logic [LW-1:0]     rd_lane;
    logic [WORD_W-1:0] lane_rd [ACCEL];

    // Split the flat image address into bank row and lane.
    always_comb begin
        rd_group = GW'(32'(raddr) / ACCEL);
        rd_lane  = LW'(32'(raddr) % ACCEL);
    end

    for (genvar l = 0; l < ACCEL; l++) begin : g_lane
        logic [WORD_W-1:0] bank [NUM_GROUPS];

        // Capture this lane's result word for the finishing group.
        always_ff @(posedge clk) begin
            if (we) bank[group] <= lanes[l*WORD_W +: WORD_W];
        end

        assign lane_rd[l] = bank[rd_group];
    end

    assign rdata = lane_rd[rd_lane];

endmodule

// File: rtl/recon_seq_ctrl.sv
// Top of the unfolding load and sequencing controller: two strobe-loaded
// memories for the engine, the sequencer, and the output image memory.
// Assumes: each word is 2*PART_W bits, real part in the upper half; the
// controller never interprets word contents.
module recon_seq_ctrl
    import recon_seq_pkg::*;
#(
    parameter  int PART_W     = 32,
    parameter  int COEF_DEPTH = 8,
    parameter  int SAMP_DEPTH = 8,
    parameter  int ACCEL      = 2,
    parameter  int NUM_GROUPS = 4,
    localparam int WORD_W     = 2 * PART_W,
    localparam int CAW        = (COEF_DEPTH > 1) ? $clog2(COEF_DEPTH) : 1,
    localparam int SAW        = (SAMP_DEPTH > 1) ? $clog2(SAMP_DEPTH) : 1,
    localparam int IMG_DEPTH  = ACCEL * NUM_GROUPS,
    localparam int IAW        = (IMG_DEPTH > 1) ? $clog2(IMG_DEPTH) : 1,
    localparam int GW         = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    coef_load,
    input  logic [WORD_W-1:0]       coef_word,
    input  logic                    data_load,
    input  logic [WORD_W-1:0]       samp_word,
    input  logic [CAW-1:0]          coef_raddr,
    output logic [WORD_W-1:0]       coef_rdata,
    input  logic [SAW-1:0]          samp_raddr,
    output logic [WORD_W-1:0]       samp_rdata,
    output logic                    eng_ready,
    output logic                    eng_go,
    output logic [GW-1:0]           eng_group,
    input  logic                    eng_done,
    input  logic [ACCEL*WORD_W-1:0] eng_result,
    input  logic [IAW-1:0]          img_raddr,
    output logic [WORD_W-1:0]       img_rdata,
    output logic [2:0]              seq_state,
    output logic                    all_done,
    output logic                    seq_err
);

    logic       load_open;
    logic       frame_clear;
    logic       coef_full;
    logic       samp_full;
    logic       img_we;
    seq_state_e state;

    recon_load_bank #(.DEPTH(COEF_DEPTH), .WORD_W(WORD_W)) coef_bank_i (
        .clk   (clk),
        .rst_n (rst_n),
        .strobe(coef_load),
        .open  (load_open),
        .clear (frame_clear),
        .wdata (coef_word),
        .raddr (coef_raddr),
        .rdata (coef_rdata),
        .full  (coef_full)
    );

    recon_load_bank #(.DEPTH(SAMP_DEPTH), .WORD_W(WORD_W)) samp_bank_i (
        .clk   (clk),
        .rst_n (rst_n),
        .strobe(data_load),
        .open  (load_open),
        .clear (frame_clear),
        .wdata (samp_word),
        .raddr (samp_raddr),
        .rdata (samp_rdata),
        .full  (samp_full)
    );

    recon_seq_fsm #(.NUM_GROUPS(NUM_GROUPS)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .coef_load  (coef_load),
        .data_load  (data_load),
        .coef_full  (coef_full),
        .samp_full  (samp_full),
        .eng_done   (eng_done),
        .state_o    (state),
        .load_open  (load_open),
        .eng_ready  (eng_ready),
        .eng_go     (eng_go),
        .group      (eng_group),
        .img_we     (img_we),
        .frame_clear(frame_clear),
        .all_done   (all_done),
        .err        (seq_err)
    );

    recon_img_store #(.ACCEL(ACCEL), .NUM_GROUPS(NUM_GROUPS), .WORD_W(WORD_W)) img_i (
        .clk  (clk),
        .we   (img_we),
        .group(eng_group),
        .lanes(eng_result),
        .raddr(img_raddr),
        .rdata(img_rdata)
    );

    assign seq_state = state;

    AST_READY_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_ready) |-> (coef_full && samp_full));                  // R4

endmodule

// File: tb/recon_seq_ctrl_tb_top.sv
module recon_seq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NG         = 4;
    localparam int WD_CYCLES  = 5000;

    // Per-group stimulus: idle cycles before done, done in go cycle, strobe with done.
    localparam int DONE_GAP  [NG] = '{0, 3, 1, 5};
    localparam bit DONE_EARLY[NG] = '{1'b0, 1'b1, 1'b0, 1'b0};
    localparam bit STROBE_HIT[NG] = '{1'b0, 1'b0, 1'b0, 1'b1};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         coef_load = 1'b0;
    logic [63:0]  coef_word = '0;
    logic         data_load = 1'b0;
    logic [63:0]  samp_word = '0;
    logic [2:0]   coef_raddr = '0;
    logic [63:0]  coef_rdata;
    logic [2:0]   samp_raddr = '0;
    logic [63:0]  samp_rdata;
    logic         eng_ready;
    logic         eng_go;
    logic [1:0]   eng_group;
    logic         eng_done = 1'b0;
    logic [127:0] eng_result = '0;
    logic [2:0]   img_raddr = '0;
    logic [63:0]  img_rdata;
    logic [2:0]   seq_state;
    logic         all_done;
    logic         seq_err;

    int n_cmp = 0;
    int n_bad = 0;
    logic [2:0] seen_state;

    always #(CLK_PERIOD / 2) clk = ~clk;

    recon_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .coef_load(coef_load), .coef_word(coef_word),
        .data_load(data_load), .samp_word(samp_word),
        .coef_raddr(coef_raddr), .coef_rdata(coef_rdata),
        .samp_raddr(samp_raddr), .samp_rdata(samp_rdata),
        .eng_ready(eng_ready), .eng_go(eng_go), .eng_group(eng_group),
        .eng_done(eng_done), .eng_result(eng_result),
        .img_raddr(img_raddr), .img_rdata(img_rdata),
        .seq_state(seq_state), .all_done(all_done), .seq_err(seq_err)
    );

    function automatic logic [63:0] cw(int f, int i);
        return {8'hC0, 8'(f), 16'(i), 32'(1000 + i)};
    endfunction
    function automatic logic [63:0] sw(int f, int i);
        return {8'h5A, 8'(f), 16'(i), 32'(2000 + i)};
    endfunction
    function automatic logic [63:0] rw(int f, int g, int k);
        return {8'hE0, 8'(f), 8'(g), 8'(k), 32'(g * 16 + k)};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Drive n words under the chosen strobes, one per cycle, then drop them.
    task automatic load(input bit do_c, input bit do_s, input int f, input int n);
        for (int i = 0; i < n; i++) begin
            coef_load = do_c;
            data_load = do_s;
            coef_word = cw(f, i);
            samp_word = sw(f, i);
            tick();
            if (i == 0) seen_state = seq_state;
        end
        coef_load = 1'b0;
        data_load = 1'b0;
    endtask

    task automatic rd_coef(input int a, output logic [63:0] d);
        coef_raddr = 3'(a); #1; d = coef_rdata;
    endtask
    task automatic rd_samp(input int a, output logic [63:0] d);
        samp_raddr = 3'(a); #1; d = samp_rdata;
    endtask
    task automatic rd_img(input int a, output logic [63:0] d);
        img_raddr = 3'(a); #1; d = img_rdata;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] d;
        // Reset state (R11, R10)
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R11 state", 64'(seq_state), 64'd0);
        chk("R11 ready", 64'(eng_ready), 64'd0);
        chk("R11 go", 64'(eng_go), 64'd0);
        chk("R11 all_done", 64'(all_done), 64'd0);
        chk("R11 err", 64'(seq_err), 64'd0);

        // Partial coefficient load, then a full one that must restart at 0 (R3)
        load(1'b1, 1'b0, 9, 3);
        chk("R10 coef-load code", 64'(seen_state), 64'd1);
        tick();
        chk("R10 idle after partial", 64'(seq_state), 64'd0);
        load(1'b1, 1'b0, 1, 10);
        tick();
        chk("R3 partial not complete, ready low", 64'(eng_ready), 64'd0);
        rd_coef(0, d); chk("R3 restart at address 0", d, cw(1, 0));
        rd_coef(7, d); chk("R1 last address keeps word 7", d, cw(1, 7));
        rd_coef(3, d); chk("R1 sequential address", d, cw(1, 3));

        // Sample load completes the frame (R2, R4)
        load(1'b0, 1'b1, 1, 8);
        chk("R10 data-load code", 64'(seen_state), 64'd2);
        chk("R4 ready low before last strobe falls", 64'(eng_ready), 64'd0);
        tick();
        chk("R4 ready after both loaded", 64'(eng_ready), 64'd1);
        chk("R10 run code", 64'(seq_state), 64'd3);
        rd_samp(0, d); chk("R2 sample word 0", d, sw(1, 0));
        rd_samp(6, d); chk("R2 sample word 6", d, sw(1, 6));

        // Table walk over the pixel groups (R5, R6, R7, R8, R9)
        for (int g = 0; g < NG; g++) begin
            chk("R5 go pulse", 64'(eng_go), 64'd1);
            chk("R5 group index", 64'(eng_group), 64'(g));
            if (DONE_EARLY[g]) begin
                eng_done = 1'b1;
                eng_result = {64'hBAD1, 64'hBAD0};
            end
            tick();
            eng_done = 1'b0;
            chk("R6 waiting after go", 64'(seq_state), 64'd4);
            chk("R5 go lasts one cycle", 64'(eng_go), 64'd0);
            chk("R6 group held", 64'(eng_group), 64'(g));
            for (int j = 0; j < DONE_GAP[g]; j++) tick();
            chk("R6 still waiting", 64'(seq_state), 64'd4);
            eng_done = 1'b1;
            eng_result = {rw(1, g, 1), rw(1, g, 0)};
            coef_load = STROBE_HIT[g];
            coef_word = 64'hDEAD_BEEF_0000_0000;
            tick();
            eng_done = 1'b0;
            coef_load = 1'b0;
            if (g < NG - 1) begin
                chk("R5 next run state", 64'(seq_state), 64'd3);
            end else begin
                chk("R8 finished code", 64'(seq_state), 64'd5);
                chk("R8 all_done pulse", 64'(all_done), 64'd1);
                chk("R8 ready dropped", 64'(eng_ready), 64'd0);
                chk("R9 err set by strobe with done", 64'(seq_err), 64'(STROBE_HIT[g]));
            end
        end
        tick();
        chk("R8 all_done one cycle", 64'(all_done), 64'd0);
        chk("R8 stays finished", 64'(seq_state), 64'd5);
        rd_coef(0, d); chk("R9 strobe mid-run wrote nothing", d, cw(1, 0));
        for (int a = 0; a < 2 * NG; a++) begin
            rd_img(a, d);
            chk("R7 image word", d, rw(1, a / 2, a % 2));
        end

        // Only samples reloaded: completeness was cleared, so no run (R8)
        load(1'b0, 1'b1, 2, 8);
        tick();
        chk("R8 reload needed, idle", 64'(seq_state), 64'd0);
        chk("R8 reload needed, ready low", 64'(eng_ready), 64'd0);

        // Both strobes together (R2, R10)
        load(1'b1, 1'b1, 3, 8);
        chk("R10 coef priority on joint rise", 64'(seen_state), 64'd1);
        tick();
        chk("R4 ready after joint load", 64'(eng_ready), 64'd1);
        rd_coef(3, d); chk("R2 joint load coefficient", d, cw(3, 3));
        rd_samp(5, d); chk("R2 joint load sample", d, sw(3, 5));
        chk("R9 err sticky", 64'(seq_err), 64'd1);

        for (int g = 0; g < NG; g++) begin
            if (g == 0) begin
                data_load = 1'b1;
                samp_word = 64'hDEAD_0000_0000_BEEF;
            end
            tick();
            data_load = 1'b0;
            eng_done = 1'b1;
            eng_result = {rw(3, g, 1), rw(3, g, 0)};
            tick();
            eng_done = 1'b0;
        end
        chk("R8 second frame finished", 64'(seq_state), 64'd5);
        rd_samp(0, d); chk("R9 strobe in run ignored", d, sw(3, 0));
        rd_img(0, d); chk("R7 frame 3 image first", d, rw(3, 0, 0));
        rd_img(7, d); chk("R7 frame 3 image last", d, rw(3, 3, 1));

        // Reset clears the sticky error (R11)
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        chk("R11 err cleared by reset", 64'(seq_err), 64'd0);
        chk("R11 idle after reset", 64'(seq_state), 64'd0);

        summary();
        $finish;
    end

endmodule